// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from the release of reset until the memory can accept normal traffic. It first keeps the bus quiet for a long power-up interval. The bus is deselected (chip select high) for most of that interval and shows NOP for a short tail at its end. It then runs the bring-up commands in a fixed order: a precharge of every bank, two auto-refresh commands, and a mode-register load that carries a word taken from an input port. Each command is followed by a counted gap.

The power-up wait and every inter-command gap are set by parameters: the clock frequency in MHz plus a time in µs or ns, or a cycle count for the mode-load gap. The block turns these into clock counts by rounding up, and no gap is shorter than two cycles. When the last gap has expired, a ready flag rises and stays high until the next reset. After that point the bus shows only NOP, so another controller can take it over.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the command bus shows the deselect code {cs_n,ras_n,cas_n,we_n}=1111, `addr` and `ba` are zero, and `ready` is low. Reset is asynchronous.
- R2: After reset is released, no code other than 1111 or NOP (0111) appears for exactly POWER_WAIT_US×CLK_MHZ cycles.
- R3: During the power-up wait, the bus shows 1111 except in the final NOP_TAIL cycles, which show NOP (0111).
- R4: In the cycle right after the wait, a single-cycle precharge (0010) is issued with address bit 10 high, every other address bit zero, and `ba` zero.
- R5: Exactly two auto-refresh commands (0001) follow. The first comes tRP cycles after the precharge and the second comes tRFC cycles after the first. Each gap is ceil(ns×CLK_MHZ/1000), with a minimum of 2.
- R6: A load-mode command (0000) is issued tRFC cycles after the second refresh, with `addr` equal to `mode_word` and `ba` zero.
- R7: `ready` rises tMRD cycles after the load-mode command (at least 2). It then stays high with NOP on the bus until reset.
- R8: In every cycle between bring-up commands, the bus shows NOP with `addr` and `ba` at zero.
- R9: A reset asserted at any point, including mid-sequence or after `ready`, restarts the whole sequence from the beginning of the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | ADDR_W | Word placed on the address bus during the mode load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BANK_W | Bank address |
| ready | output | 1 | Bring-up complete, held high until reset |

## Verification
The sequence is run with two different mode words, 0x032 and 0x237. Because their bit patterns differ, a dropped, swapped or stale address bit shows up only in the load-mode cycle, and any leak of the word into other cycles breaks the all-zero address expected there. Every cycle of each run is compared with a timeline built from the event table. This separates an off-by-one in the power-up wait from one in an individual tRP, tRFC or tMRD gap, and it catches a missing, doubled or reordered refresh. Reset is applied twice more: once after `ready` is high and once inside the first refresh gap. This shows whether the sequencer truly restarts from the long wait rather than resuming where it stopped.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command codes on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESELECT  = 4'b1111,
    CMD_NOP       = 4'b0111,
    CMD_PRECHARGE = 4'b0010,
    CMD_REFRESH   = 4'b0001,
    CMD_LOAD_MODE = 4'b0000
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_POWER_WAIT,
    ST_PRECHARGE,
    ST_PRE_GAP,
    ST_REFRESH_A,
    ST_REFRESH_A_GAP,
    ST_REFRESH_B,
    ST_REFRESH_B_GAP,
    ST_LOAD_MODE,
    ST_MODE_GAP,
    ST_READY
  } init_state_e;

  // Clock cycles in a microsecond-scale wait
  function automatic int unsigned power_wait_cycles(int unsigned wait_us, int unsigned clk_mhz);
    return wait_us * clk_mhz;
  endfunction

  // Issue-to-issue distance, never below two cycles
  function automatic int unsigned clamp_gap(int unsigned cycles);
    return (cycles < 2) ? 2 : cycles;
  endfunction

  // Nanoseconds to clock cycles, rounded up, then clamped
  function automatic int unsigned ns_gap_cycles(int unsigned t_ns, int unsigned clk_mhz);
    return clamp_gap((t_ns * clk_mhz + 999) / 1000);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CW    = 16,
  parameter int unsigned START = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= CW'(START);
    else if (load)         count <= load_val;
    else if (count != '0)  count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CW      = 16,
  parameter int unsigned TRP_LD  = 2,
  parameter int unsigned TRFC_LD = 12,
  parameter int unsigned TMRD_LD = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expired,
  output init_state_e   state,
  output logic          load,
  output logic [CW-1:0] load_val
);

  init_state_e nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_POWER_WAIT:    if (expired) nxt = ST_PRECHARGE;
      ST_PRECHARGE: begin
        nxt = ST_PRE_GAP;       load = 1'b1; load_val = CW'(TRP_LD);
      end
      ST_PRE_GAP:       if (expired) nxt = ST_REFRESH_A;
      ST_REFRESH_A: begin
        nxt = ST_REFRESH_A_GAP; load = 1'b1; load_val = CW'(TRFC_LD);
      end
      ST_REFRESH_A_GAP: if (expired) nxt = ST_REFRESH_B;
      ST_REFRESH_B: begin
        nxt = ST_REFRESH_B_GAP; load = 1'b1; load_val = CW'(TRFC_LD);
      end
      ST_REFRESH_B_GAP: if (expired) nxt = ST_LOAD_MODE;
      ST_LOAD_MODE: begin
        nxt = ST_MODE_GAP;      load = 1'b1; load_val = CW'(TMRD_LD);
      end
      ST_MODE_GAP:      if (expired) nxt = ST_READY;
      ST_READY:         nxt = ST_READY;
      default:          nxt = ST_POWER_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_POWER_WAIT;
    else        state <= nxt;
  end

endmodule

// File: rtl/sdram_init_drive.sv
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned NOP_TAIL = 4
) (
  input  init_state_e       state,
  input  logic [CW-1:0]     count,
  input  logic [ADDR_W-1:0] mode_word,
  output sdram_cmd_e        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              wait_tail
);

  localparam int unsigned ALL_BANK_BIT = 10;

  assign wait_tail = (state == ST_POWER_WAIT) && (count < CW'(NOP_TAIL));
  assign ba        = '0;

  always_comb begin
    addr = '0;
    unique case (state)
      ST_POWER_WAIT: cmd = wait_tail ? CMD_NOP : CMD_DESELECT;
      ST_PRECHARGE: begin
        cmd = CMD_PRECHARGE;
        addr[ALL_BANK_BIT] = 1'b1;
      end
      ST_REFRESH_A,
      ST_REFRESH_B:  cmd = CMD_REFRESH;
      ST_LOAD_MODE: begin
        cmd  = CMD_LOAD_MODE;
        addr = mode_word;
      end
      default:       cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 200,
  parameter int unsigned POWER_WAIT_US = 100,
  parameter int unsigned TRP_NS        = 20,
  parameter int unsigned TRFC_NS       = 70,
  parameter int unsigned TMRD_CLK      = 2,
  parameter int unsigned NOP_TAIL      = 4,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BANK_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              ready
);

  localparam int unsigned WAIT_CYC = power_wait_cycles(POWER_WAIT_US, CLK_MHZ);
  localparam int unsigned TRP_CYC  = ns_gap_cycles(TRP_NS, CLK_MHZ);
  localparam int unsigned TRFC_CYC = ns_gap_cycles(TRFC_NS, CLK_MHZ);
  localparam int unsigned TMRD_CYC = clamp_gap(TMRD_CLK);
  localparam int unsigned MAX_CYC  = max2(max2(WAIT_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  init_state_e   state;
  sdram_cmd_e    cmd;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] tmr_count;
  logic          tmr_expired;
  logic          wait_tail;

  sdram_init_timer #(.CW(CW), .START(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .count(tmr_count), .expired(tmr_expired)
  );

  sdram_init_fsm #(
    .CW(CW), .TRP_LD(TRP_CYC - 2), .TRFC_LD(TRFC_CYC - 2), .TMRD_LD(TMRD_CYC - 2)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(tmr_expired),
    .state(state), .load(tmr_load), .load_val(tmr_val)
  );

  sdram_init_drive #(
    .CW(CW), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NOP_TAIL(NOP_TAIL)
  ) u_drive (
    .state(state), .count(tmr_count), .mode_word(mode_word),
    .cmd(cmd), .addr(addr), .ba(ba), .wait_tail(wait_tail)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ready = (state == ST_READY);

endmodule

// File: rtl/sdram_init_seq_checker.sv
module sdram_init_seq_checker #(
  parameter int unsigned TRP_CYC  = 4,
  parameter int unsigned TRFC_CYC = 14,
  parameter int unsigned TMRD_CYC = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BANK_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] mode_word,
  input logic              ready,
  input logic              wait_tail
);

  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [1:0] L_NONE = 2'd0, L_PRE = 2'd1, L_REF = 2'd2, L_LMR = 2'd3;

  logic [15:0] gap;
  logic [1:0]  last;
  logic [1:0]  refs;
  logic        issued;

  assign issued = (cmd != C_NOP) && (cmd != C_DES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; last <= L_NONE; refs <= '0;
    end else begin
      if (issued) gap <= 16'd1;
      else if (gap != 16'hFFFF) gap <= gap + 16'd1;
      if (cmd == C_PRE) last <= L_PRE;
      if (cmd == C_REF) begin
        last <= L_REF;
        if (refs != 2'd3) refs <= refs + 2'd1;
      end
      if (cmd == C_LMR) last <= L_LMR;
    end
  end

  a_r2_quiet_before_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    (last == L_NONE) |-> (cmd == C_NOP || cmd == C_DES || cmd == C_PRE));
  a_r3_tail_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    wait_tail |-> (cmd == C_NOP));
  a_r3_deselect_before_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (last == L_NONE && !wait_tail && cmd != C_PRE) |-> (cmd == C_DES));
  a_r4_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (addr[10] && ba == '0 && last == L_NONE));
  a_r5_first_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && last == L_PRE) |-> (gap == 16'(TRP_CYC)));
  a_r5_second_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && last == L_REF) |-> (gap == 16'(TRFC_CYC) && refs == 2'd1));
  a_r6_load_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR) |-> (last == L_REF && refs == 2'd2 && gap == 16'(TRFC_CYC)
                        && addr == mode_word && ba == '0));
  a_r7_ready_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (last == L_LMR && gap == 16'(TMRD_CYC)));
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r7_idle_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == C_NOP && addr == '0));
  a_r8_idle_address: assert property (@(posedge clk) disable iff (!rst_n)
    (!issued) |-> (addr == '0 && ba == '0));

endmodule

bind sdram_init_seq sdram_init_seq_checker #(
  .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC),
  .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd({cs_n, ras_n, cas_n, we_n}),
  .addr(addr), .ba(ba), .mode_word(mode_word), .ready(ready),
  .wait_tail(wait_tail)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

  // 200 MHz: 5 ns period
  localparam int PERIOD_NS = 5;
  localparam int W    = 100 * 1000 / PERIOD_NS;
  localparam int TRP  = (20 + PERIOD_NS - 1) / PERIOD_NS;
  localparam int TRFC = (70 + PERIOD_NS - 1) / PERIOD_NS;
  localparam int TMRD = 2;
  localparam int TAIL = 4;

  // Event table: cycle after reset release, command code, tag
  localparam int N_EV = 5;
  localparam int EV_AT [N_EV] = '{W, W + TRP, W + TRP + TRFC, W + TRP + 2*TRFC,
                                  W + TRP + 2*TRFC + TMRD};
  localparam logic [3:0] EV_CMD [N_EV] = '{4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0111};
  localparam int READY_AT = EV_AT[N_EV-1];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mode_word = '0;
  logic        cs_n, ras_n, cas_n, we_n, ready;
  logic [11:0] addr;
  logic [1:0]  ba;

  int checks = 0;
  int errors = 0;

  sdram_init_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .ready(ready)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cmd/addr/ba/ready got=%b_%h_%b_%b exp=%b_%h_%b_%b", tag,
               got[18:15], got[14:3], got[2:1], got[0],
               exp[18:15], exp[14:3], exp[2:1], exp[0]);
    end
  endtask

  function automatic logic [18:0] observed();
    return {cs_n, ras_n, cas_n, we_n, addr, ba, ready};
  endfunction

  function automatic logic [18:0] expected(input int c, input logic [11:0] mw);
    logic [3:0]  e_cmd;
    logic [11:0] e_addr;
    e_addr = '0;
    if (c < W - TAIL)  e_cmd = 4'b1111;
    else               e_cmd = 4'b0111;
    for (int i = 0; i < N_EV - 1; i++)
      if (c == EV_AT[i]) begin
        e_cmd = EV_CMD[i];
        if (EV_CMD[i] == 4'b0010) e_addr = 12'h400;
        if (EV_CMD[i] == 4'b0000) e_addr = mw;
      end
    return {e_cmd, e_addr, 2'b00, (c >= READY_AT)};
  endfunction

  function automatic string tag_for(input int c);
    if (c < W - TAIL) return "R2";
    if (c < W)        return "R3";
    if (c == EV_AT[0]) return "R4";
    if (c == EV_AT[1] || c == EV_AT[2]) return "R5";
    if (c == EV_AT[3]) return "R6";
    if (c >= READY_AT) return "R7";
    return "R8";
  endfunction

  // Release reset and compare every cycle with the table timeline
  task automatic run_seq(input logic [11:0] mw, input int last_c);
    mode_word = mw;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c <= last_c; c++) begin
      #1 check(tag_for(c), observed(), expected(c, mw));
      @(negedge clk);
    end
  endtask

  task automatic reset_check(input string tag, input int n);
    rst_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1 check(tag, observed(), {4'b1111, 12'h000, 2'b00, 1'b0});
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * PERIOD_NS);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: state under reset
    @(negedge clk);
    reset_check("R1", 3);
    // First full bring-up, then observe ready holding (R7)
    run_seq(12'h032, READY_AT + 40);
    // R9: reset after ready clears it at once and restarts
    reset_check("R9", 2);
    // Abort inside the first refresh gap
    run_seq(12'h5A7, EV_AT[1] + 5);
    reset_check("R9", 2);
    // Full run with another mode word
    run_seq(12'h237, READY_AT + 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule